// File: doc/BRIEF.md
# Parallel-Port Register Access Sequencer

This block runs single-register accesses to a remote adapter over a byte-wide parallel port, on the host side. A request gives a transfer mode, a bank select, a 7-bit register index and, for writes, a data byte. The block forms an 8-bit address: the bank bit is the top bit, so the control bank adds 0x80. It scrambles that address with a key that depends on the mode and the direction. It then steps through a fixed list of data-port drives, control-port codes and input captures. For reads, it rebuilds the returned byte from the captured fragments and pulses `done` with the result.

There are three read modes. Nibble mode takes two 4-bit halves from the first status port. Split mode takes a 5-bit part from the first status port and a 3-bit part from the second. Byte mode reads the data port directly. Writes use the same short sequence in every mode. Each step stays on the port for `STEP_CLKS` clocks, so the port timing can be slowed. A request with the unused mode code does not touch the port. It completes at once with an error flag and an all-ones result.

Top module: `ppreg_seq`

## Requirements
- R1: After reset, `pc_out` is 0x04, `pd_out` is 0x00, and `busy`, `done` and `err` are low. Whenever the block is idle, `pc_out` is 0x04.
- R2: The access address is `{req_bank, req_index}`, so bank 1 adds 0x80 to the index.
- R3: A nibble read (mode 0) with r = address XOR 0x39 does these steps in order: drive r, control 0x01, control 0x03, drive r, capture `ps1_in` as A, control 0x01, capture `ps1_in` as B, control 0x04.
- R4: The nibble result is {B[7:4], A[7:4]}.
- R5: A split read (mode 1) with r = address XOR 0x31 does these steps in order: drive r, control 0x01, drive r AND 0x37, control 0x03, control 0x05, drive r OR 0xF0, capture `ps1_in` as A, capture `ps2_in` as B, control 0x04.
- R6: The split result is {B[3:1], A[7:3]}.
- R7: A byte read (mode 2) with r = address XOR 0x29 does these steps in order: drive r, control 0x01, control 0x21, control 0x23, capture `pd_in`, control 0x04. The result is the captured byte.
- R8: A write in modes 0, 1 or 2 does these steps in order: drive address XOR 0x19, control 0x01, drive the write data, control 0x03, control 0x04.
- R9: Every step holds for `STEP_CLKS` clocks. `done` rises N*`STEP_CLKS` clocks after the accepting edge, where N is 8, 9, 6 or 5 for nibble, split, byte and write respectively.
- R10: Mode 3 runs no sequence. `done` and `err` pulse on the edge after acceptance, `rd_data` is 0xFF, and the port outputs do not change. `err` is low for every other request.
- R11: A request is accepted only while `busy` is low. A request made while busy is ignored. `done` lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mode | input | 2 | 0 nibble, 1 split, 2 byte, 3 invalid |
| req_bank | input | 1 | 0 register file, 1 control bank |
| req_index | input | 7 | Register index |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Invalid mode, pulses with done |
| rd_data | output | 8 | Read result, valid with done |
| pd_out | output | 8 | Parallel data port drive |
| pc_out | output | 8 | Parallel control port code |
| pd_in | input | 8 | Parallel data port readback |
| ps1_in | input | 8 | First status port |
| ps2_in | input | 8 | Second status port |

## Verification
A wrong step index or key shows up on `pd_out`/`pc_out` within one hold period as a control code or drive value out of order. Comparing the full port trace of each request catches it by the end of that request. A capture taken into the wrong slot, or from the wrong port, changes only `rd_data`. The bench therefore makes the status inputs depend on the current control code, so each capture point sees a different value. A fault in the hold counter shifts the `done` latency and also trips the minimum-hold property on the next port change.

// File: rtl/ppreg_pkg.sv
package ppreg_pkg;
  typedef enum logic [1:0] {M_NIB = 2'd0, M_SPLIT = 2'd1, M_BYTE = 2'd2, M_BAD = 2'd3} mode_e;
  typedef enum logic [2:0] {S_DRV, S_CTL, S_CAPA, S_CAPB1, S_CAPB2, S_CAPD} kind_e;

  typedef struct packed {
    kind_e      kind;
    logic [7:0] val;
    logic       last;
  } step_t;

  localparam logic [7:0] KEY_NIB   = 8'h39;
  localparam logic [7:0] KEY_SPLIT = 8'h31;
  localparam logic [7:0] KEY_BYTE  = 8'h29;
  localparam logic [7:0] KEY_WR    = 8'h19;
  localparam logic [7:0] CTL_IDLE  = 8'h04;
  localparam int         STEP_W    = 4;

  function automatic step_t mk(kind_e k, logic [7:0] v, logic l);
    step_t s;
    s.kind = k;
    s.val  = v;
    s.last = l;
    return s;
  endfunction
endpackage

// File: rtl/ppreg_prog.sv
module ppreg_prog import ppreg_pkg::*; (
  input  mode_e             mode,
  input  logic              wr,
  input  logic [7:0]        addr,
  input  logic [7:0]        wdata,
  input  logic [STEP_W-1:0] idx,
  output step_t             step
);
  logic [7:0] key;
  logic [7:0] r;

  always_comb begin
    if (wr) key = KEY_WR;
    else begin
      case (mode)
        M_NIB:   key = KEY_NIB;
        M_SPLIT: key = KEY_SPLIT;
        default: key = KEY_BYTE;
      endcase
    end
  end

  assign r = addr ^ key;

  always_comb begin
    step = mk(S_CTL, CTL_IDLE, 1'b1);
    if (wr) begin
      case (idx)
        4'd0:    step = mk(S_DRV, r, 1'b0);
        4'd1:    step = mk(S_CTL, 8'h01, 1'b0);
        4'd2:    step = mk(S_DRV, wdata, 1'b0);
        4'd3:    step = mk(S_CTL, 8'h03, 1'b0);
        default: step = mk(S_CTL, CTL_IDLE, 1'b1);
      endcase
    end else begin
      case (mode)
        M_NIB: begin
          case (idx)
            4'd0:    step = mk(S_DRV, r, 1'b0);
            4'd1:    step = mk(S_CTL, 8'h01, 1'b0);
            4'd2:    step = mk(S_CTL, 8'h03, 1'b0);
            4'd3:    step = mk(S_DRV, r, 1'b0);
            4'd4:    step = mk(S_CAPA, 8'h00, 1'b0);
            4'd5:    step = mk(S_CTL, 8'h01, 1'b0);
            4'd6:    step = mk(S_CAPB1, 8'h00, 1'b0);
            default: step = mk(S_CTL, CTL_IDLE, 1'b1);
          endcase
        end
        M_SPLIT: begin
          case (idx)
            4'd0:    step = mk(S_DRV, r, 1'b0);
            4'd1:    step = mk(S_CTL, 8'h01, 1'b0);
            4'd2:    step = mk(S_DRV, r & 8'h37, 1'b0);
            4'd3:    step = mk(S_CTL, 8'h03, 1'b0);
            4'd4:    step = mk(S_CTL, 8'h05, 1'b0);
            4'd5:    step = mk(S_DRV, r | 8'hF0, 1'b0);
            4'd6:    step = mk(S_CAPA, 8'h00, 1'b0);
            4'd7:    step = mk(S_CAPB2, 8'h00, 1'b0);
            default: step = mk(S_CTL, CTL_IDLE, 1'b1);
          endcase
        end
        default: begin
          case (idx)
            4'd0:    step = mk(S_DRV, r, 1'b0);
            4'd1:    step = mk(S_CTL, 8'h01, 1'b0);
            4'd2:    step = mk(S_CTL, 8'h21, 1'b0);
            4'd3:    step = mk(S_CTL, 8'h23, 1'b0);
            4'd4:    step = mk(S_CAPD, 8'h00, 1'b0);
            default: step = mk(S_CTL, CTL_IDLE, 1'b1);
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/ppreg_merge.sv
module ppreg_merge import ppreg_pkg::*; (
  input  mode_e      mode,
  input  logic [7:0] cap_a,
  input  logic [7:0] cap_b,
  output logic [7:0] byte_o
);
  always_comb begin
    case (mode)
      M_NIB:   byte_o = {cap_b[7:4], cap_a[7:4]};
      M_SPLIT: byte_o = {cap_b[3:1], cap_a[7:3]};
      default: byte_o = cap_a;
    endcase
  end
endmodule

// File: rtl/ppreg_seq.sv
module ppreg_seq import ppreg_pkg::*; #(
  parameter int STEP_CLKS = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic       req_write,
  input  logic [1:0] req_mode,
  input  logic       req_bank,
  input  logic [6:0] req_index,
  input  logic [7:0] req_wdata,
  output logic       busy,
  output logic       done,
  output logic       err,
  output logic [7:0] rd_data,
  output logic [7:0] pd_out,
  output logic [7:0] pc_out,
  input  logic [7:0] pd_in,
  input  logic [7:0] ps1_in,
  input  logic [7:0] ps2_in
);
  localparam int CNT_W = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1;
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(STEP_CLKS - 1);

  mode_e             op_mode;
  logic              op_wr;
  logic [7:0]        op_addr;
  logic [7:0]        op_wd;
  logic [STEP_W-1:0] step_idx;
  logic [CNT_W-1:0]  cnt;
  logic [7:0]        cap_a;
  logic [7:0]        cap_b;
  step_t             cur;
  logic [7:0]        merged;

  ppreg_prog u_prog (
    .mode  (op_mode),
    .wr    (op_wr),
    .addr  (op_addr),
    .wdata (op_wd),
    .idx   (step_idx),
    .step  (cur)
  );

  ppreg_merge u_merge (
    .mode   (op_mode),
    .cap_a  (cap_a),
    .cap_b  (cap_b),
    .byte_o (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      rd_data  <= 8'h00;
      pd_out   <= 8'h00;
      pc_out   <= CTL_IDLE;
      op_mode  <= M_NIB;
      op_wr    <= 1'b0;
      op_addr  <= 8'h00;
      op_wd    <= 8'h00;
      step_idx <= '0;
      cnt      <= '0;
      cap_a    <= 8'h00;
      cap_b    <= 8'h00;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          if (mode_e'(req_mode) == M_BAD) begin
            done    <= 1'b1;
            err     <= 1'b1;
            rd_data <= 8'hFF;
          end else begin
            busy     <= 1'b1;
            op_mode  <= mode_e'(req_mode);
            op_wr    <= req_write;
            op_addr  <= {req_bank, req_index};
            op_wd    <= req_wdata;
            step_idx <= '0;
            cnt      <= '0;
          end
        end
      end else begin
        if (cnt == '0) begin
          case (cur.kind)
            S_DRV:   pd_out <= cur.val;
            S_CTL:   pc_out <= cur.val;
            S_CAPA:  cap_a  <= ps1_in;
            S_CAPB1: cap_b  <= ps1_in;
            S_CAPB2: cap_b  <= ps2_in;
            S_CAPD:  cap_a  <= pd_in;
            default: ;
          endcase
        end
        if (cnt == CNT_END) begin
          cnt <= '0;
          if (cur.last) begin
            busy <= 1'b0;
            done <= 1'b1;
            if (!op_wr) rd_data <= merged;
          end else begin
            step_idx <= step_idx + 1'b1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ppreg_seq_chk.sv
module ppreg_seq_chk #(
  parameter int STEP_CLKS = 1
) (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic [7:0] rd_data,
  input logic [7:0] pd_out,
  input logic [7:0] pc_out
);
  logic [15:0] prev_port;
  logic [15:0] since;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_port <= {8'h04, 8'h00};
      since     <= '0;
    end else begin
      prev_port <= {pc_out, pd_out};
      if ({pc_out, pd_out} != prev_port) since <= '0;
      else if (since != 16'hFFFF) since <= since + 1'b1;
    end
  end

  assert_idle_ctl_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> pc_out == 8'h04);

  assert_hold_min_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && ({pc_out, pd_out} != prev_port)) |-> since >= 16'(STEP_CLKS - 1));

  assert_err_result_R10: assert property (@(posedge clk) disable iff (rst)
    err |-> (done && rd_data == 8'hFF));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_start_req_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid));
endmodule

bind ppreg_seq ppreg_seq_chk #(.STEP_CLKS(STEP_CLKS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .rd_data   (rd_data),
  .pd_out    (pd_out),
  .pc_out    (pc_out)
);

// File: tb/ppreg_seq_test.sv
`timescale 1ns/1ps
module ppreg_seq_test;
  localparam int H = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, req_bank = 1'b0;
  logic [1:0] req_mode = 2'd0;
  logic [6:0] req_index = 7'd0;
  logic [7:0] req_wdata = 8'd0;
  logic busy, done, err;
  logic [7:0] rd_data, pd_out, pc_out, pd_in, ps1_in, ps2_in;
  logic [7:0] va = 8'h00, vb = 8'h00, vd = 8'h00;

  always #2 clk = ~clk;

  assign ps1_in = (pc_out == 8'h03 || pc_out == 8'h05) ? va : vb;
  assign ps2_in = vb;
  assign pd_in  = (pc_out == 8'h23) ? vd : ~vd;

  ppreg_seq #(.STEP_CLKS(H)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_mode(req_mode), .req_bank(req_bank), .req_index(req_index),
    .req_wdata(req_wdata), .busy(busy), .done(done), .err(err),
    .rd_data(rd_data), .pd_out(pd_out), .pc_out(pc_out),
    .pd_in(pd_in), .ps1_in(ps1_in), .ps2_in(ps2_in)
  );

  int n_chk = 0, n_bad = 0;
  logic [8:0] obs_q[$];
  logic [8:0] exp_q[$];
  bit rec = 0;
  logic [7:0] lpd = 8'h00, lpc = 8'h04;
  logic [7:0] mpd = 8'h00, mpc = 8'h04;

  always @(negedge clk) begin
    if (pd_out !== lpd) begin
      if (rec) obs_q.push_back({1'b0, pd_out});
      lpd = pd_out;
    end
    if (pc_out !== lpc) begin
      if (rec) obs_q.push_back({1'b1, pc_out});
      lpc = pc_out;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic ex(bit isctl, logic [7:0] v);
    if (isctl) begin
      if (v != mpc) exp_q.push_back({1'b1, v});
      mpc = v;
    end else begin
      if (v != mpd) exp_q.push_back({1'b0, v});
      mpd = v;
    end
  endtask

  function automatic int nsteps(bit wr, logic [1:0] m);
    if (m == 2'd3) return 0;
    if (wr) return 5;
    case (m)
      2'd0: return 8;
      2'd1: return 9;
      default: return 6;
    endcase
  endfunction

  function automatic logic [7:0] exp_rd(logic [1:0] m);
    case (m)
      2'd0: return {vb[7:4], va[7:4]};
      2'd1: return {vb[3:1], va[7:3]};
      default: return vd;
    endcase
  endfunction

  task automatic build(bit wr, logic [1:0] m, logic [7:0] a, logic [7:0] wd);
    logic [7:0] r;
    if (m == 2'd3) return;
    if (wr) begin
      r = a ^ 8'h19;
      ex(0, r); ex(1, 8'h01); ex(0, wd); ex(1, 8'h03); ex(1, 8'h04);
    end else if (m == 2'd0) begin
      r = a ^ 8'h39;
      ex(0, r); ex(1, 8'h01); ex(1, 8'h03); ex(0, r); ex(1, 8'h01); ex(1, 8'h04);
    end else if (m == 2'd1) begin
      r = a ^ 8'h31;
      ex(0, r); ex(1, 8'h01); ex(0, r & 8'h37); ex(1, 8'h03); ex(1, 8'h05);
      ex(0, r | 8'hF0); ex(1, 8'h04);
    end else begin
      r = a ^ 8'h29;
      ex(0, r); ex(1, 8'h01); ex(1, 8'h21); ex(1, 8'h23); ex(1, 8'h04);
    end
  endtask

  task automatic run(bit wr, logic [1:0] m, bit bank, logic [6:0] idx,
                     logic [7:0] wd, bit intr);
    int cnt;
    int n;
    bit tr_ok;
    string tag;
    @(negedge clk);
    req_write = wr; req_mode = m; req_bank = bank; req_index = idx;
    req_wdata = wd; req_valid = 1'b1;
    obs_q.delete(); exp_q.delete();
    build(wr, m, {bank, idx}, wd);
    rec = 1;
    n = nsteps(wr, m);
    cnt = 0;
    forever begin
      @(negedge clk);
      cnt++;
      req_valid = intr && (cnt == 3);
      if (intr && cnt == 3) begin
        req_mode = 2'd3; req_write = ~wr;
      end
      if (cnt == 2 && m != 2'd3)
        check(busy === 1'b1, "R11", "busy during sequence", busy, 1);
      if (done === 1'b1 || cnt > 1000) break;
    end
    #1;
    rec = 0;
    check(cnt == n * H + 1, "R9", "done latency", cnt - 1, n * H);
    tag = wr ? "R8" : (m == 2'd0 ? "R3" : (m == 2'd1 ? "R5" : "R7"));
    if (m == 2'd3) tag = "R10";
    tr_ok = (obs_q.size() == exp_q.size());
    if (tr_ok) foreach (exp_q[i]) if (obs_q[i] !== exp_q[i]) tr_ok = 0;
    check(tr_ok, tag, bank ? "port trace (R2 bank)" : "port trace",
          obs_q.size(), exp_q.size());
    if (m == 2'd3) begin
      check(err === 1'b1 && rd_data === 8'hFF, "R10", "error result", rd_data, 8'hFF);
    end else begin
      check(err === 1'b0, "R10", "no error", err, 0);
      if (!wr)
        check(rd_data === exp_rd(m), m == 2'd0 ? "R4" : (m == 2'd1 ? "R6" : "R7"),
              "read data", rd_data, exp_rd(m));
    end
    @(negedge clk);
    check(done === 1'b0, "R11", "done single cycle", done, 0);
    if (intr) begin
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        check(done === 1'b0 && busy === 1'b0, "R11", "request while busy ignored",
              {busy, done}, 0);
      end
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(pc_out === 8'h04 && pd_out === 8'h00, "R1", "reset ports",
          {pc_out, pd_out}, 16'h0400);
    check(busy === 0 && done === 0 && err === 0, "R1", "reset flags",
          {busy, done, err}, 0);

    va = 8'hA5; vb = 8'h3C; vd = 8'h96;
    run(0, 2'd0, 1'b0, 7'h00, 8'h00, 0);
    run(0, 2'd1, 1'b1, 7'h06, 8'h00, 0);
    run(0, 2'd2, 1'b1, 7'h7F, 8'h00, 0);
    run(1, 2'd0, 1'b1, 7'h06, 8'h08, 0);
    run(1, 2'd2, 1'b0, 7'h02, 8'hAA, 0);
    run(0, 2'd3, 1'b0, 7'h11, 8'h00, 0);
    run(1, 2'd3, 1'b1, 7'h11, 8'h55, 0);
    run(0, 2'd1, 1'b0, 7'h03, 8'h00, 1);
    va = 8'hFF; vb = 8'h00; vd = 8'h00;
    run(0, 2'd0, 1'b0, 7'h39, 8'h00, 0);
    run(0, 2'd1, 1'b0, 7'h31, 8'h00, 0);

    for (int t = 0; t < 60; t++) begin
      va = 8'($urandom); vb = 8'($urandom); vd = 8'($urandom);
      run(1'($urandom), 2'($urandom), 1'($urandom), 7'($urandom),
          8'($urandom), (t % 10) == 5);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule